// File: doc/BRIEF.md
# Multi-format serial audio port

This block is a slave-side stereo serial audio port. A bit clock, a frame clock and a serial data line come in from an external master. The block recovers one left and one right sample per frame and presents both as 24-bit parallel words with a single-cycle strobe. In the other direction, it takes a pair of 24-bit parallel words and shifts them out on its own serial data line, timed by the same bit clock and frame clock.

A 3-bit code chooses the framing: I2S, left-justified, right-justified 16-bit or right-justified 24-bit. A 2-bit code sets the frame length to 32, 48, 64 or 128 bit clocks.

The port runs on a fast system clock. It synchronises the external clocks and detects their edges in that clock domain, so the surrounding logic sees only one clock. The expected reset setting of the format code is 001 (I2S), and the usual frame code is 10 (64 bit clocks). Both codes are plain inputs, held by the logic that contains the port.

Top module: `sap_port`

## Requirements
- R1: After reset, `rx_left` and `rx_right` are zero, `rx_valid` is low and `sdout` is low.
- R2: With format code 001 (I2S), the left word occupies the half frame where `lrck` is low. Its MSB is taken on the second rising `bclk` edge of that half, which is slot 1 after the frame-clock change.
- R3: With format code 000 (left-justified), the left word occupies the half frame where `lrck` is high. Its MSB is taken on the first rising `bclk` edge of that half, which is slot 0.
- R4: With format code 101 (right-justified 24-bit), the 24 bits end on the last slot of each half frame, so the LSB is in slot H-1 and the MSB in slot H-24. In this format the left word occupies the half where `lrck` is high.
- R5: With format code 010 (right-justified 16-bit), 16 bits end on the last slot of the half frame. A word with fewer than 24 received bits appears left-aligned in the 24-bit output, with zeros in the unfilled low bits. This also applies when a short half frame truncates a word.
- R6: Exactly one single-cycle `rx_valid` pulse is issued per frame, after the right half has ended. Both words change only together with that pulse.
- R7: `sdout` changes only after a falling `bclk` edge. It carries the transmit words MSB first, in the same slot positions that the receive side uses for the selected format.
- R8: In transmit slots that lie outside the word's span, `sdout` is 0. This covers the slots before and after the word and the bits beyond 16 in the 16-bit format.
- R9: Frame code `frame_sel` 00, 01, 10 and 11 gives half frames of 16, 24, 32 and 64 bit clocks. The right-justified placement and the truncation of words follow that half length.
- R10: With a reserved format code (011, 100, 110 or 111), no `rx_valid` pulse is issued and `sdout` stays 0.
- R11: `tx_left` and `tx_right` are both captured at the falling `bclk` edge that begins the left half. Later changes to these inputs do not affect the frame already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `bclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt | input | 3 | Framing code (000 left-justified, 001 I2S, 010 right-justified 16, 101 right-justified 24) |
| frame_sel | input | 2 | Bit clocks per frame (00 32, 01 48, 10 64, 11 128) |
| bclk | input | 1 | External bit clock |
| lrck | input | 1 | External frame clock |
| sdin | input | 1 | Serial playback data, sampled on rising `bclk` |
| rx_left | output | 24 | Received left word, left-aligned |
| rx_right | output | 24 | Received right word, left-aligned |
| rx_valid | output | 1 | One-cycle strobe when both words are updated |
| tx_left | input | 24 | Left capture word to send |
| tx_right | input | 24 | Right capture word to send |
| sdout | output | 1 | Serial capture data, changes after falling `bclk` |

## Verification
The hardest conditions to reach are the ones where the half-frame length and the word length disagree. These are a 16-slot half carrying a 24-bit left-justified word, a 24-slot half carrying an I2S word, and a 64-slot half in which a right-justified word starts 40 slots in. The stimulus reaches each of them by resetting the port, pairing a format code with a frame code, and streaming whole frames. Each frame is followed by one trailing frame-clock change, so that the final pair is released.

The transmit words are inverted right after the first slot of every frame. A port that failed to hold its captured words would therefore put visibly wrong bits on `sdout`.

// File: rtl/sap_port.sv
module sap_port #(
  parameter int W      = 24,
  parameter int NARROW = 16,
  parameter int CW     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   fmt,
  input  logic [1:0]   frame_sel,
  input  logic         bclk,
  input  logic         lrck,
  input  logic         sdin,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic         sdout
);
  localparam int IW = $clog2(W);
  localparam logic [CW-1:0] SMAX = '1;

  logic [2:0] bs, ls, ds;
  logic rise, fall, lr, din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bs <= '0;
      ls <= '0;
      ds <= '0;
    end else begin
      bs <= {bs[1:0], bclk};
      ls <= {ls[1:0], lrck};
      ds <= {ds[1:0], sdin};
    end

  assign rise = bs[1] & ~bs[2];
  assign fall = ~bs[1] & bs[2];
  assign lr   = ls[1];
  assign din  = ds[1];

  logic ok, i2s;
  int   half, wl, off;

  always_comb begin
    case (frame_sel)
      2'b00:   half = 16;
      2'b01:   half = 24;
      2'b10:   half = 32;
      default: half = 64;
    endcase
    ok  = 1'b1;
    i2s = 1'b0;
    wl  = W;
    off = 0;
    case (fmt)
      3'b000: ;
      3'b001: begin i2s = 1'b1; off = 1; end
      3'b010: begin wl = NARROW; off = half - NARROW; end
      3'b101: off = half - W;
      default: ok = 1'b0;
    endcase
  end

  function automatic logic [IW:0] locate(input logic [CW-1:0] s, input int o, input int n);
    int d;
    d = int'(s) - o;
    if (d >= 0 && d < n) return {1'b1, IW'(W - 1 - d)};
    return '0;
  endfunction

  logic [CW-1:0] slot, nslot;
  logic          lr_last, lr_edge, left_lvl;
  logic [IW:0]   loc;
  logic          hit;
  logic [IW-1:0] idx;

  assign left_lvl = ~i2s;
  assign lr_edge  = lr != lr_last;
  assign nslot    = lr_edge ? '0 : ((slot == SMAX) ? slot : slot + 1'b1);
  assign loc      = locate(nslot, off, wl);
  assign hit      = loc[IW];
  assign idx      = loc[IW-1:0];

  logic [W-1:0] acc, acc_n, lpend;
  logic         started, have_l;

  always_comb begin
    acc_n = lr_edge ? '0 : acc;
    if (hit) acc_n[idx] = din;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot     <= '0;
      lr_last  <= 1'b0;
      acc      <= '0;
      lpend    <= '0;
      started  <= 1'b0;
      have_l   <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        lr_last <= lr;
        slot    <= nslot;
        acc     <= acc_n;
        if (lr_edge) begin
          started <= 1'b1;
          if (started && ok) begin
            if (lr_last == left_lvl) begin
              lpend  <= acc;
              have_l <= 1'b1;
            end else if (have_l) begin
              rx_left  <= lpend;
              rx_right <= acc;
              rx_valid <= 1'b1;
              have_l   <= 1'b0;
            end
          end
        end
      end
    end

  logic [W-1:0] shl, shr, tword;
  logic         tleft, tstart, sdo_q;

  assign tleft  = lr == left_lvl;
  assign tstart = lr_edge & tleft;
  assign tword  = tstart ? tx_left : (tleft ? shl : shr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shl   <= '0;
      shr   <= '0;
      sdo_q <= 1'b0;
    end else if (fall) begin
      if (tstart) begin
        shl <= tx_left;
        shr <= tx_right;
      end
      sdo_q <= hit & tword[idx];
    end

  assign sdout = sdo_q & ok;
endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt,
  input logic        rx_valid,
  input logic [23:0] rx_left,
  input logic [23:0] rx_right,
  input logic        sdout,
  input logic        fall
);
  logic reserved;
  assign reserved = !(fmt == 3'b000 || fmt == 3'b001 || fmt == 3'b010 || fmt == 3'b101);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_words_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

  a_r7_out_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdout) && $stable(fmt)) |-> $past(fall));

  a_r10_reserved_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reserved) |-> !rx_valid);

  a_r5_narrow_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(fmt) == 3'b010) |-> (rx_left[7:0] == 8'd0 && rx_right[7:0] == 8'd0));
endmodule

bind sap_port sap_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(fmt), .rx_valid(rx_valid),
  .rx_left(rx_left), .rx_right(rx_right), .sdout(sdout), .fall(fall)
);

// File: tb/test_sap_port.sv
`timescale 1ns/1ps
module test_sap_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  fmt = 3'b001;
  logic [1:0]  frame_sel = 2'b10;
  logic        bclk = 1'b1, lrck = 1'b1, sdin = 1'b0;
  logic [23:0] rx_left, rx_right, tx_left = '0, tx_right = '0;
  logic        rx_valid, sdout;

  sap_port i_sap_port (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .frame_sel(frame_sel),
    .bclk(bclk), .lrck(lrck), .sdin(sdin),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .tx_left(tx_left), .tx_right(tx_right), .sdout(sdout)
  );

  int checks = 0, errors = 0;
  logic [47:0] expq[$];
  string cur_rtag = "R1";

  function automatic int halfof(input logic [1:0] fs);
    case (fs) 2'b00: return 16; 2'b01: return 24; 2'b10: return 32; default: return 64; endcase
  endfunction
  function automatic bit fmt_ok(input logic [2:0] f);
    return f == 3'b000 || f == 3'b001 || f == 3'b010 || f == 3'b101;
  endfunction
  function automatic int offs(input logic [2:0] f, input int h);
    case (f) 3'b001: return 1; 3'b010: return h - 16; 3'b101: return h - 24; default: return 0; endcase
  endfunction
  function automatic logic bitof(input logic [23:0] w, input logic [2:0] f, input int h, input int k);
    int d, n;
    n = (f == 3'b010) ? 16 : 24;
    d = k - offs(f, h);
    if (d >= 0 && d < n) return w[23-d];
    return 1'b0;
  endfunction
  function automatic logic [23:0] expw(input logic [23:0] w, input logic [2:0] f, input int h);
    logic [23:0] e = '0;
    for (int k = 0; k < h; k++) begin
      int d = k - offs(f, h);
      if (d >= 0 && d < ((f == 3'b010) ? 16 : 24)) e[23-d] = w[23-d];
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n === 1'b1 && rx_valid === 1'b1) begin
      if (expq.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL %s actual=unexpected valid expected=no valid", cur_rtag);
      end else begin
        logic [47:0] e;
        e = expq.pop_front();
        chk(cur_rtag, {rx_left, rx_right}, e);
      end
    end

  task automatic slot_bit(input logic lv, input logic dv, input logic ex, input bit do_chk, input string tag);
    @(negedge clk);
    bclk = 1'b0; lrck = lv; sdin = dv;
    repeat (3) @(negedge clk);
    if (do_chk) chk(tag, {47'd0, sdout}, {47'd0, ex});
    @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                            input logic [23:0] tl, input logic [23:0] tr, input string ttag);
    int h = halfof(frame_sel);
    logic ll = (fmt == 3'b001) ? 1'b0 : 1'b1;
    bit ok = fmt_ok(fmt);
    tx_left = tl; tx_right = tr;
    for (int k = 0; k < h; k++) begin
      slot_bit(ll, bitof(l, fmt, h, k), ok ? bitof(tl, fmt, h, k) : 1'b0, 1, ttag);
      if (k == 0) begin tx_left = ~tl; tx_right = ~tr; end
    end
    for (int k = 0; k < h; k++)
      slot_bit(~ll, bitof(r, fmt, h, k), ok ? bitof(tr, fmt, h, k) : 1'b0, 1, ttag);
    if (ok) expq.push_back({expw(l, fmt, h), expw(r, fmt, h)});
  endtask

  task automatic run_seq(input logic [2:0] f, input logic [1:0] fs, input string rtag,
                         input string ttag, input int n, input bit first);
    logic ll = (f == 3'b001) ? 1'b0 : 1'b1;
    rst_n = 1'b0; fmt = f; frame_sel = fs; lrck = ~ll; bclk = 1'b1; sdin = 1'b0;
    expq.delete();
    cur_rtag = rtag;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    if (first) begin
      chk("R1", {rx_left, rx_right}, 48'd0);
      chk("R1", {46'd0, rx_valid, sdout}, 48'd0);
    end
    for (int i = 0; i < 4; i++) slot_bit(~ll, 1'b0, 1'b0, 0, "");
    for (int i = 0; i < n; i++)
      send_frame(24'h9A3C51 ^ {i[7:0], 16'h5A0F}, 24'h3E81D7 ^ {8'h4C, i[7:0], 8'hB2},
                 24'hC0FFEE ^ {i[7:0], 16'h1234}, 24'h5B6D2A ^ {16'h0F0F, i[7:0]}, ttag);
    for (int i = 0; i < 2; i++) slot_bit(ll, 1'b0, 1'b0, 0, "");
    repeat (12) @(negedge clk);
    chk("R6", {16'd0, 32'(expq.size())}, 48'd0);
  endtask

  initial begin
    run_seq(3'b001, 2'b10, "R2", "R11", 3, 1);
    run_seq(3'b000, 2'b10, "R3", "R7", 2, 0);
    run_seq(3'b101, 2'b10, "R4", "R7", 2, 0);
    run_seq(3'b010, 2'b10, "R5", "R8", 2, 0);
    run_seq(3'b000, 2'b00, "R9", "R9", 2, 0);
    run_seq(3'b001, 2'b01, "R9", "R8", 1, 0);
    run_seq(3'b101, 2'b11, "R9", "R9", 1, 0);
    run_seq(3'b011, 2'b10, "R10", "R10", 2, 0);
    run_seq(3'b110, 2'b00, "R10", "R10", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule